// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a serial peripheral slave that lets a host read and write a small bank of 8-bit registers over a four-wire link. The link has a chip select, a serial clock, a serial data input and an open-drain serial data output, built from a pull-down enable and the bit being presented. Each transaction is framed by chip select. It carries a command bit, a 7-bit register address and an 8-bit data field, all most significant bit first.

The slave presents a fixed alignment byte on its output while the host sends the command and address. In a read it then presents the contents of the addressed register. A write is committed to the register bank only on the last rising clock edge of a full-length frame, so a frame that ends early leaves the bank untouched. All serial logic runs on the serial clock. Chip select high clears the frame state asynchronously, and the register bank takes a one-edge write strobe with address and data.

Top module: `spi_addr_slave`

## Requirements
- R1: While `rst_n` is low every register of the bank is cleared to 0x00 asynchronously; after reset every mapped address reads 0x00.
- R2: In the first eight bit slots of every frame, read or write, the output presents the alignment byte 0x25, most significant bit first.
- R3: The first bit of a frame is the command: 0 selects a write and 1 selects a read. The data bits of a read frame are ignored, and the addressed register keeps its value.
- R4: Bits 2 to 8 of a frame are the register address, most significant bit first, captured on the 8th rising edge and held to the end of the frame. Registers sit at addresses 0 to 3. A read of any other address returns 0x00, and a write to one changes no register.
- R5: In a read frame, bit slots 9 to 16 present the addressed register, most significant bit first. In a write frame those slots are released (the line reads 1), and so is every slot after the 16th in any frame.
- R6: A write updates the register on the 16th rising edge of the frame. A frame that ends before that edge changes nothing, and clock edges after the 16th cause no further write.
- R7: Chip select high clears the bit count and the shift state, so the frame after an aborted one decodes from its first bit.
- R8: Clock idle low and clock idle high are both supported: input is sampled on rising edges and the output changes on falling edges, and both give the same slot timing.
- R9: The output only ever pulls low (`sdo_pd` high) and is released whenever chip select is high, including when a frame is abandoned in the middle of a driven-low bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of the register bank and frame state |
| cs_n | input | 1 | Active-low chip select framing each transaction |
| sclk | input | 1 | Serial clock; the only clock of the block |
| sdi | input | 1 | Serial data from the host, sampled on rising edges |
| sdo_o | output | 1 | Bit currently presented on the serial output (1 means released) |
| sdo_pd | output | 1 | Pull-down enable of the open-drain serial output |

## Verification
The hardest situation to reach from the ports is a frame that stops one edge short of the commit point. That is the 15-bit write, where every data bit is already shifted in and only the strobe edge is missing. The bench produces it by cutting the clock burst at a chosen count, then reads the register back to show it is untouched. A 5-bit header fragment followed by a full write shows the count restarts cleanly. The idle-high clock phase is covered by running write and read frames with the clock parked high, so each falling edge comes before its rising edge.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  // Command encoding carried by the first bit of a frame
  typedef enum logic {
    CMD_WRITE = 1'b0,
    CMD_READ  = 1'b1
  } cmd_e;

  // Pattern shifted out during the command/address phase
  localparam logic [7:0] ALIGN_BYTE = 8'h25;

endpackage

// File: rtl/spi_slv_rx.sv
// Receive side: counts rising edges, captures the header and produces the
// one-edge write strobe on the final bit of a full frame.
module spi_slv_rx
  import spi_slv_pkg::*;
#(
  parameter  int ADDR_W     = 7,
  parameter  int DATA_W     = 8,
  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W,
  localparam int HDR_BITS   = 1 + ADDR_W,
  localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic              sclk,
  input  logic              frame_clr_n,
  input  logic              sdi,
  output logic [CNT_W-1:0]  cnt,
  output cmd_e              cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data
);

  localparam int SH_W = ((ADDR_W > DATA_W) ? ADDR_W : DATA_W) - 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SH_W-1:0]   sh_q, sh_d;
  cmd_e              cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              cnt_en, hdr_last, frm_last;

  // next state
  always_comb begin
    cnt_en   = (cnt_q != CNT_W'(FRAME_BITS));
    hdr_last = (cnt_q == CNT_W'(HDR_BITS - 1));
    frm_last = (cnt_q == CNT_W'(FRAME_BITS - 1));
    cnt_d    = cnt_en ? cnt_q + 1'b1 : cnt_q;
    sh_d     = {sh_q[SH_W-2:0], sdi};
    cmd_d    = hdr_last ? cmd_e'(sh_q[ADDR_W-1]) : cmd_q;
    addr_d   = hdr_last ? {sh_q[ADDR_W-2:0], sdi} : addr_q;
    wr_en    = frm_last && (cmd_q == CMD_WRITE);
    wr_data  = {sh_q[DATA_W-2:0], sdi};
  end

  // registers, cleared while chip select is high
  always_ff @(posedge sclk or negedge frame_clr_n) begin
    if (!frame_clr_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      cmd_q  <= CMD_WRITE;
      addr_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      sh_q   <= sh_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
    end
  end

  assign cnt  = cnt_q;
  assign cmd  = cmd_q;
  assign addr = addr_q;

endmodule

// File: rtl/spi_slv_tx.sv
// Transmit side: follows the receive count on falling edges and selects the
// alignment pattern, the read byte, or a released line.
module spi_slv_tx
  import spi_slv_pkg::*;
#(
  parameter  int ADDR_W     = 7,
  parameter  int DATA_W     = 8,
  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W,
  localparam int HDR_BITS   = 1 + ADDR_W,
  localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic              sclk,
  input  logic              frame_clr_n,
  input  logic              cs_n,
  input  logic [CNT_W-1:0]  rx_cnt,
  input  cmd_e              cmd,
  input  logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  idx,
  output logic              sdo_o,
  output logic              sdo_pd
);

  localparam logic [HDR_BITS-1:0] ALIGN_V = HDR_BITS'(ALIGN_BYTE);

  logic [CNT_W-1:0]      idx_q;
  logic [DATA_W-1:0]     data_q, data_d;
  logic                  data_en;
  logic [FRAME_BITS-1:0] pattern;
  logic                  bit_v;

  // next state and output select
  always_comb begin
    data_en = (rx_cnt == CNT_W'(HDR_BITS));
    data_d  = data_en ? rd_data : data_q;
    pattern = {ALIGN_V, (cmd == CMD_READ) ? data_q : {DATA_W{1'b1}}};
    bit_v   = 1'b1;
    for (int i = 0; i < FRAME_BITS; i++) begin
      if (idx_q == CNT_W'(i)) bit_v = pattern[FRAME_BITS-1-i];
    end
  end

  // falling-edge registers, cleared while chip select is high
  always_ff @(negedge sclk or negedge frame_clr_n) begin
    if (!frame_clr_n) begin
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      idx_q <= rx_cnt;
      if (data_en) data_q <= data_d;
    end
  end

  assign idx    = idx_q;
  assign sdo_o  = bit_v;
  assign sdo_pd = !cs_n && !bit_v;

endmodule

// File: rtl/spi_slv_regs.sv
// Register bank: one write strobe per frame, combinational read port.
module spi_slv_regs #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] word_w [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    logic              hit;
    logic [DATA_W-1:0] word_q;

    always_comb hit = wr_en && (wr_addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= wr_data;
    end

    assign word_w[g] = word_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = word_w[i];
    end
  end

endmodule

// File: rtl/spi_addr_slave.sv
// Top: serial register access slave.
module spi_addr_slave
  import spi_slv_pkg::*;
#(
  parameter  int ADDR_W     = 7,
  parameter  int DATA_W     = 8,
  parameter  int NUM_REGS   = 4,
  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W,
  localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo_o,
  output logic sdo_pd
);

  logic              frame_clr_n;
  logic [CNT_W-1:0]  rx_cnt;
  logic [CNT_W-1:0]  tx_idx;
  cmd_e              cmd;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  assign frame_clr_n = rst_n && !cs_n;

  spi_slv_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .sclk        (sclk),
    .frame_clr_n (frame_clr_n),
    .sdi         (sdi),
    .cnt         (rx_cnt),
    .cmd         (cmd),
    .addr        (addr_q),
    .wr_en       (wr_en),
    .wr_data     (wr_data)
  );

  spi_slv_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk     (sclk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (addr_q),
    .wr_data (wr_data),
    .rd_addr (addr_q),
    .rd_data (rd_data)
  );

  spi_slv_tx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
    .sclk        (sclk),
    .frame_clr_n (frame_clr_n),
    .cs_n        (cs_n),
    .rx_cnt      (rx_cnt),
    .cmd         (cmd),
    .rd_data     (rd_data),
    .idx         (tx_idx),
    .sdo_o       (sdo_o),
    .sdo_pd      (sdo_pd)
  );

endmodule

// File: rtl/spi_slv_chk.sv
// Property checker bound to the top module.
module spi_slv_chk #(
  parameter  int ADDR_W     = 7,
  parameter  int DATA_W     = 8,
  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W,
  localparam int HDR_BITS   = 1 + ADDR_W,
  localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input logic              sclk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sdo_pd,
  input logic              cmd_rd,
  input logic              wr_en,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic [CNT_W-1:0]  tx_idx,
  input logic [ADDR_W-1:0] addr_q
);

  // R9
  always_comb begin
    if (rst_n === 1'b1 && cs_n === 1'b1) begin
      idle_release_chk: assert (sdo_pd == 1'b0);
    end
  end

  // R8
  phase_track_chk: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    tx_idx == rx_cnt);

  // R4
  addr_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    (rx_cnt > CNT_W'(HDR_BITS)) |-> $stable(addr_q));

  // R6
  commit_edge_chk: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    wr_en |-> ($past(rx_cnt) == CNT_W'(FRAME_BITS - 2)));

  // R5
  release_chk: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    ((tx_idx >= CNT_W'(FRAME_BITS)) || ((tx_idx >= CNT_W'(HDR_BITS)) && !cmd_rd))
      |-> !sdo_pd);

  // R3
  read_nowrite_chk: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    (cmd_rd && (rx_cnt >= CNT_W'(HDR_BITS))) |-> !wr_en);

endmodule

bind spi_addr_slave spi_slv_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .sclk   (sclk),
  .rst_n  (rst_n),
  .cs_n   (cs_n),
  .sdo_pd (sdo_pd),
  .cmd_rd (cmd == spi_slv_pkg::CMD_READ),
  .wr_en  (wr_en),
  .rx_cnt (rx_cnt),
  .tx_idx (tx_idx),
  .addr_q (addr_q)
);

// File: tb/tb_spi_addr_slave.sv
`timescale 1ns/1ps
module tb_spi_addr_slave;

  logic rst_n, cs_n, sclk, sdi;
  logic sdo_o, sdo_pd;
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  spi_addr_slave dut (
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .sclk   (sclk),
    .sdi    (sdi),
    .sdo_o  (sdo_o),
    .sdo_pd (sdo_pd)
  );

  // {frame[15:0], expected read byte}; write frames ignore the last field
  localparam int NV = 9;
  localparam logic [23:0] VEC [NV] = '{
    24'h00A5_00,  // write reg0 <- A5
    24'h013C_00,  // write reg1 <- 3C
    24'h0381_00,  // write reg3 <- 81
    24'h45FF_00,  // write unmapped 0x45 <- FF
    24'h80FF_A5,  // read reg0, data bits all ones (ignored)
    24'h8112_3C,  // read reg1
    24'h8300_81,  // read reg3
    24'h8200_00,  // read reg2, never written
    24'hC500_00   // read unmapped 0x45, no alias onto reg1
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One framed transfer; 250 MHz serial clock (4 ns period)
  task automatic xfer(input bit m3, input int nb, input logic [15:0] tx,
                      output logic [23:0] rx);
    rx   = '1;
    sclk = m3;
    #2;
    cs_n = 1'b0;
    #2;
    for (int i = 0; i < nb; i++) begin
      if (m3) sclk = 1'b0;
      sdi = (i < 16) ? tx[15-i] : 1'b1;
      #2;
      if (i < 24) rx[23-i] = sdo_pd ? 1'b0 : 1'b1;
      sclk = 1'b1;
      #2;
      if (!m3) sclk = 1'b0;
    end
    #2;
    cs_n = 1'b1;
    #1;
    chk({15'd0, sdo_pd}, 16'd0, "R9 released after frame");
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] rx;
    rst_n = 1'b0;
    cs_n  = 1'b1;
    sclk  = 1'b0;
    sdi   = 1'b0;
    #10;
    chk({15'd0, sdo_pd}, 16'd0, "R1 idle output in reset");
    rst_n = 1'b1;
    #4;

    // R1: every mapped register reads zero after reset
    for (int a = 0; a < 4; a++) begin
      xfer(1'b0, 16, {1'b1, 7'(a), 8'h00}, rx);
      chk({8'd0, rx[23:16]}, 16'h0025, "R2 alignment");
      chk({8'd0, rx[15:8]}, 16'h0000, "R1 reset value");
    end

    // Table walk: R3/R4/R5 reads, R6 writes
    for (int v = 0; v < NV; v++) begin
      xfer(1'b0, 16, VEC[v][23:8], rx);
      chk({8'd0, rx[23:16]}, 16'h0025, "R2 alignment");
      if (VEC[v][23]) chk({8'd0, rx[15:8]}, {8'd0, VEC[v][7:0]}, "R3/R4/R5 read data");
      else            chk({8'd0, rx[15:8]}, 16'h00FF, "R5 released in write frame");
    end

    // R5: slots after the 16th are released; R6: extra edges do not write
    xfer(1'b0, 20, 16'h8100, rx);
    chk({8'd0, rx[15:8]}, 16'h003C, "R5 long read data");
    chk({12'd0, rx[7:4]}, 16'h000F, "R5 release after 16th slot");

    // R6: a write cut one edge short leaves the register unchanged
    xfer(1'b0, 15, 16'h0277, rx);
    xfer(1'b0, 16, 16'h8200, rx);
    chk({8'd0, rx[15:8]}, 16'h0000, "R6 short write dropped");
    chk({8'd0, rx[23:16]}, 16'h0025, "R7 alignment after abort");

    // R7: a header fragment does not shift the next frame
    xfer(1'b0, 5, 16'hFFFF, rx);
    xfer(1'b0, 16, 16'h01C3, rx);
    xfer(1'b0, 16, 16'h8100, rx);
    chk({8'd0, rx[15:8]}, 16'h00C3, "R7 write after fragment");

    // R8: clock idle high
    xfer(1'b1, 16, 16'h035A, rx);
    chk({8'd0, rx[23:16]}, 16'h0025, "R8 alignment idle-high write");
    xfer(1'b1, 16, 16'h8300, rx);
    chk({8'd0, rx[23:16]}, 16'h0025, "R8 alignment idle-high read");
    chk({8'd0, rx[15:8]}, 16'h005A, "R8 read idle-high");
    xfer(1'b0, 16, 16'h8300, rx);
    chk({8'd0, rx[15:8]}, 16'h005A, "R8 idle-high write seen idle-low");

    // R9: abandon a frame while a low bit is driven (slot 4 of 0x25 is 0)
    sclk = 1'b0;
    #2;
    cs_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      sdi = 1'b1;
      #2;
      sclk = 1'b1;
      #2;
      sclk = 1'b0;
    end
    #1;
    chk({15'd0, sdo_pd}, 16'd1, "R2/R9 pull-down in alignment slot");
    cs_n = 1'b1;
    #1;
    chk({15'd0, sdo_pd}, 16'd0, "R9 release on chip select high");
    #2;

    // R1: asynchronous reset clears written registers
    rst_n = 1'b0;
    #4;
    rst_n = 1'b1;
    #4;
    xfer(1'b0, 16, 16'h8000, rx);
    chk({8'd0, rx[15:8]}, 16'h0000, "R1 cleared by reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule